// File: doc/BRIEF.md
# Paged and Indirect Data Address Generator

This block forms the 16-bit data-memory address for a small signal-processing core. Each access picks one of two modes. In paged mode, a 9-bit page register supplies the upper address bits and a 7-bit offset from the instruction supplies the lower bits, which reaches 512 pages of 128 words. In pointer mode, the address is the contents of one of eight 16-bit pointer registers, chosen by a 3-bit select register.

After a pointer-mode access, a small arithmetic unit can rewrite the register that was just used. It can increment it, decrement it, or add or subtract the value of register 0. Because the unit works on the register file, it also serves as a general adder and subtractor. The same access can also load a new value into the select register.

Separate load ports write the page register, the select register and any pointer register directly. All register contents are brought out so that the surrounding core can read them.

Top module: `dag_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, the page register, the select register and all eight pointer registers read zero.
- R2: When the access is in paged mode (acc_indirect_i = 0), addr_o equals the page register in bits 15:7 and acc_ofs_i in bits 6:0, combinationally in the same cycle.
- R3: When the access is in pointer mode (acc_indirect_i = 1), addr_o equals the pointer register whose index is held in the select register, combinationally in the same cycle.
- R4: A pointer-mode access with acc_valid_i = 1 updates the selected register at the next clock edge according to acc_op_i, and all arithmetic wraps modulo 2^16. The codes are 0 = hold, 1 = add 1, 2 = subtract 1, 3 = add register 0, and 4 = subtract register 0.
- R5: Operations 3 and 4 use the value register 0 holds before the edge, including when register 0 is itself the selected register.
- R6: Codes 5 to 7 leave the registers unchanged. A paged-mode access ignores acc_op_i and acc_ptr_wr_i, and changes no pointer register and not the select register.
- R7: A pointer-mode access with acc_ptr_wr_i = 1 loads acc_ptr_val_i into the select register at the next edge. The address of that access still uses the old select value, and so does the register update.
- R8: The loads page_ld_i, sel_ld_i and ar_ld_i take effect at the next edge. Without a load or an access write, the page register and the select register hold their values.
- R9: If ar_ld_i targets the register that the access is updating, the load wins. If sel_ld_i and an access pointer write happen in the same cycle, sel_ld_i wins.
- R10: With acc_valid_i = 0, no update and no access pointer write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | An access happens this cycle |
| acc_indirect_i | input | 1 | 1 = pointer mode, 0 = paged mode |
| acc_ofs_i | input | 7 | Instruction offset for paged mode |
| acc_op_i | input | 3 | Post-access arithmetic code |
| acc_ptr_wr_i | input | 1 | Load a new select value after this access |
| acc_ptr_val_i | input | 3 | New select value |
| page_ld_i | input | 1 | Load the page register |
| page_val_i | input | 9 | Page register load value |
| sel_ld_i | input | 1 | Load the select register directly |
| sel_val_i | input | 3 | Select register load value |
| ar_ld_i | input | 1 | Load a pointer register |
| ar_ld_idx_i | input | 3 | Index of the pointer register to load |
| ar_ld_val_i | input | 16 | Pointer register load value |
| addr_o | output | 16 | Effective data address |
| ar_flat_o | output | 128 | All pointer registers, register k in bits 16k+15:16k |
| sel_o | output | 3 | Select register |
| page_o | output | 9 | Page register |

## Verification
The address is combinational, so it is due in the same cycle as the access. The bench drives each stimulus just after the falling edge and compares addr_o a moment later, before the next rising edge. Register updates, select writes and loads are due one rising edge later. The bench therefore checks them at the sample point of the following cycle, against a model that it advances only on that edge. The vector table holds hand-derived addresses for a chain of accesses in which each result depends on the updates before it.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_ADD0 = 3'd3,
    OP_SUB0 = 3'd4
  } dag_op_e;
endpackage

// File: rtl/dag_ptr_regs.sv
module dag_ptr_regs #(
  parameter int DP_W  = 9,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_ld,
  input  logic [DP_W-1:0]  page_val,
  input  logic             sel_ld,
  input  logic [SEL_W-1:0] sel_val,
  input  logic             acc_sel_wr,
  input  logic [SEL_W-1:0] acc_sel_val,
  output logic [DP_W-1:0]  page_q,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      sel_q  <= '0;
    end else begin
      if (page_ld) page_q <= page_val;
      if (sel_ld) sel_q <= sel_val;
      else if (acc_sel_wr) sel_q <= acc_sel_val;
    end
  end

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld |=> page_q == $past(page_val)); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ld && !acc_sel_wr) |=> $stable(sel_q)); // R8
  AST_SEL_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ld && acc_sel_wr) |=> sel_q == $past(sel_val)); // R9
endmodule

// File: rtl/dag_ar_arith.sv
module dag_ar_arith
  import dag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] ar0,
  input  logic [2:0]   op,
  output logic [W-1:0] nxt,
  output logic         modifies
);
  function automatic logic [W-1:0] step_value(input logic [W-1:0] v,
                                              input logic [W-1:0] base,
                                              input logic [2:0]   code);
    logic [W-1:0] r;
    case (code)
      OP_INC:  r = v + W'(1);
      OP_DEC:  r = v - W'(1);
      OP_ADD0: r = v + base;
      OP_SUB0: r = v - base;
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic logic is_modifying(input logic [2:0] code);
    return (code == OP_INC) || (code == OP_DEC) ||
           (code == OP_ADD0) || (code == OP_SUB0);
  endfunction

  assign nxt      = step_value(cur, ar0, op);
  assign modifies = is_modifying(op);
endmodule

// File: rtl/dag_ar_file.sv
module dag_ar_file #(
  parameter int NUM = 8,
  parameter int W   = 16,
  parameter int IW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [IW-1:0]  ld_idx,
  input  logic [W-1:0]   ld_val,
  input  logic           upd_en,
  input  logic [IW-1:0]  upd_idx,
  input  logic [W-1:0]   upd_val,
  output logic [NUM*W-1:0] ar_flat
);
  logic [W-1:0] ar_r [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) ar_r[i] <= '0;
      else if (ld_en && ld_idx == IW'(i)) ar_r[i] <= ld_val;
      else if (upd_en && upd_idx == IW'(i)) ar_r[i] <= upd_val;
    end
    assign ar_flat[i*W +: W] = ar_r[i];
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ar_r[$past(ld_idx)] == $past(ld_val)); // R9
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
  import dag_pkg::*;
#(
  parameter int DP_W   = 9,
  parameter int OFS_W  = 7,
  parameter int NUM_AR = 8,
  parameter int SEL_W  = $clog2(NUM_AR)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid_i,
  input  logic                          acc_indirect_i,
  input  logic [OFS_W-1:0]              acc_ofs_i,
  input  logic [2:0]                    acc_op_i,
  input  logic                          acc_ptr_wr_i,
  input  logic [SEL_W-1:0]              acc_ptr_val_i,
  input  logic                          page_ld_i,
  input  logic [DP_W-1:0]               page_val_i,
  input  logic                          sel_ld_i,
  input  logic [SEL_W-1:0]              sel_val_i,
  input  logic                          ar_ld_i,
  input  logic [SEL_W-1:0]              ar_ld_idx_i,
  input  logic [DP_W+OFS_W-1:0]         ar_ld_val_i,
  output logic [DP_W+OFS_W-1:0]         addr_o,
  output logic [NUM_AR*(DP_W+OFS_W)-1:0] ar_flat_o,
  output logic [SEL_W-1:0]              sel_o,
  output logic [DP_W-1:0]               page_o
);
  localparam int ADDR_W = DP_W + OFS_W;

  logic [DP_W-1:0]   page_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] ar_arr [NUM_AR];
  logic [ADDR_W-1:0] ar_sel_val;
  logic [ADDR_W-1:0] ar_next;
  logic              op_modifies;
  logic              ind_access;
  logic              ar_upd_en;
  logic              acc_sel_wr;

  assign ind_access = acc_valid_i && acc_indirect_i;
  assign ar_upd_en  = ind_access && op_modifies;
  assign acc_sel_wr = ind_access && acc_ptr_wr_i;

  dag_ptr_regs #(.DP_W(DP_W), .SEL_W(SEL_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .page_ld(page_ld_i), .page_val(page_val_i),
    .sel_ld(sel_ld_i), .sel_val(sel_val_i),
    .acc_sel_wr(acc_sel_wr), .acc_sel_val(acc_ptr_val_i),
    .page_q(page_q), .sel_q(sel_q)
  );

  dag_ar_file #(.NUM(NUM_AR), .W(ADDR_W), .IW(SEL_W)) u_file (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ar_ld_i), .ld_idx(ar_ld_idx_i), .ld_val(ar_ld_val_i),
    .upd_en(ar_upd_en), .upd_idx(sel_q), .upd_val(ar_next),
    .ar_flat(ar_flat_o)
  );

  for (genvar k = 0; k < NUM_AR; k++) begin : g_unpack
    assign ar_arr[k] = ar_flat_o[k*ADDR_W +: ADDR_W];
  end

  assign ar_sel_val = ar_arr[sel_q];

  dag_ar_arith #(.W(ADDR_W)) u_arith (
    .cur(ar_sel_val), .ar0(ar_arr[0]), .op(acc_op_i),
    .nxt(ar_next), .modifies(op_modifies)
  );

  assign addr_o = acc_indirect_i ? ar_sel_val : {page_q, acc_ofs_i};
  assign sel_o  = sel_q;
  assign page_o = page_q;

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_access && acc_op_i == OP_INC && !ar_ld_i)
      |=> ar_arr[$past(sel_q)] == $past(addr_o) + ADDR_W'(1)); // R4
  AST_SUB0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_access && acc_op_i == OP_SUB0 && !ar_ld_i)
      |=> ar_arr[$past(sel_q)] == $past(addr_o) - $past(ar_arr[0])); // R5
  AST_DIRECT_NO_AR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_indirect_i && !ar_ld_i && !sel_ld_i)
      |=> ($stable(ar_flat_o) && $stable(sel_o))); // R6
  AST_IDLE_NO_AR: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid_i && !ar_ld_i && !sel_ld_i)
      |=> ($stable(ar_flat_o) && $stable(sel_o))); // R10
endmodule

// File: tb/dag_addr_gen_tb.sv
module dag_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid_i = 1'b0, acc_indirect_i = 1'b0;
  logic [6:0]  acc_ofs_i = '0;
  logic [2:0]  acc_op_i = '0;
  logic        acc_ptr_wr_i = 1'b0;
  logic [2:0]  acc_ptr_val_i = '0;
  logic        page_ld_i = 1'b0;
  logic [8:0]  page_val_i = '0;
  logic        sel_ld_i = 1'b0;
  logic [2:0]  sel_val_i = '0;
  logic        ar_ld_i = 1'b0;
  logic [2:0]  ar_ld_idx_i = '0;
  logic [15:0] ar_ld_val_i = '0;
  logic [15:0] addr_o;
  logic [127:0] ar_flat_o;
  logic [2:0]  sel_o;
  logic [8:0]  page_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_ar [8];
  logic [8:0]  m_pg;
  logic [2:0]  m_sel;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  dag_addr_gen u_dut (.*);

  // {indirect, offset, op, ptr_wr, ptr_val, expected address}
  localparam logic [30:0] VEC [12] = '{
    {1'b0, 7'h12, 3'd1, 1'b0, 3'd0, 16'h5292},
    {1'b1, 7'h00, 3'd1, 1'b0, 3'd0, 16'h1000},
    {1'b1, 7'h00, 3'd3, 1'b1, 3'd2, 16'h1001},
    {1'b1, 7'h00, 3'd1, 1'b0, 3'd0, 16'hFFFF},
    {1'b1, 7'h00, 3'd2, 1'b1, 3'd3, 16'h0000},
    {1'b1, 7'h00, 3'd2, 1'b0, 3'd0, 16'h0000},
    {1'b1, 7'h00, 3'd4, 1'b1, 3'd0, 16'hFFFF},
    {1'b1, 7'h00, 3'd3, 1'b0, 3'd0, 16'h0004},
    {1'b1, 7'h00, 3'd0, 1'b1, 3'd1, 16'h0008},
    {1'b0, 7'h7F, 3'd4, 1'b1, 3'd5, 16'h52FF},
    {1'b1, 7'h00, 3'd6, 1'b0, 3'd0, 16'h1005},
    {1'b1, 7'h00, 3'd1, 1'b0, 3'd0, 16'h1005}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(input int k);
    return ar_flat_o[k*16 +: 16];
  endfunction

  task automatic idle_inputs();
    acc_valid_i = 0; acc_indirect_i = 0; acc_ptr_wr_i = 0; acc_op_i = 0;
    page_ld_i = 0; sel_ld_i = 0; ar_ld_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_inputs(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    foreach (m_ar[k]) m_ar[k] = '0;
    m_pg = '0; m_sel = '0;
  endtask

  task automatic load_reg(input logic [2:0] k, input logic [15:0] v);
    @(negedge clk); idle_inputs();
    ar_ld_i = 1; ar_ld_idx_i = k; ar_ld_val_i = v;
    @(posedge clk); m_ar[k] = v;
  endtask

  // reference: delta applied to the register used by the access
  function automatic logic [15:0] model_next(input logic [15:0] v, input logic [2:0] op);
    logic signed [17:0] d;
    case (op)
      3'd1: d = 18'sd1;
      3'd2: d = -18'sd1;
      3'd3: d = $signed({2'b00, m_ar[0]});
      3'd4: d = -$signed({2'b00, m_ar[0]});
      default: d = 18'sd0;
    endcase
    return 16'($signed({2'b00, v}) + d);
  endfunction

  task automatic check_state(input string tag);
    for (int k = 0; k < 8; k++) chk(tag, reg_of(k), m_ar[k]);
    chk(tag, {13'd0, sel_o}, {13'd0, m_sel});
    chk(tag, {7'd0, page_o}, {7'd0, m_pg});
  endtask

  // apply the current inputs for one edge and advance the model
  task automatic model_edge();
    logic [15:0] nv;
    logic [2:0]  s;
    s = m_sel;
    if (acc_valid_i && acc_indirect_i) begin
      nv = model_next(m_ar[s], acc_op_i);
      m_ar[s] = nv;
      if (acc_ptr_wr_i) m_sel = acc_ptr_val_i;
    end
    if (ar_ld_i) m_ar[ar_ld_idx_i] = ar_ld_val_i;
    if (sel_ld_i) m_sel = sel_val_i;
    if (page_ld_i) m_pg = page_val_i;
    @(posedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    idle_inputs();
    @(negedge clk); @(negedge clk);
    foreach (m_ar[k]) m_ar[k] = '0;
    m_pg = '0; m_sel = '0;
    #1 check_state("R1 during reset");
    rst_n = 1;
    @(negedge clk); #1 check_state("R1 after reset");
    chk("R1 R2 direct at page 0", addr_o, 16'h0000);

    // setup for the table
    @(negedge clk); idle_inputs(); page_ld_i = 1; page_val_i = 9'h0A5;
    sel_ld_i = 1; sel_val_i = 3'd1;
    @(posedge clk);
    m_pg = 9'h0A5; m_sel = 3'd1;
    load_reg(3'd0, 16'h0004); load_reg(3'd1, 16'h1000);
    load_reg(3'd2, 16'hFFFF); load_reg(3'd3, 16'h0000);
    for (int k = 4; k < 8; k++) load_reg(3'(k), 16'h4000 + 16'(k));
    @(negedge clk); idle_inputs(); #1 check_state("R8 loads");

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 12; v++) begin
      @(negedge clk); idle_inputs();
      acc_valid_i = 1;
      {acc_indirect_i, acc_ofs_i, acc_op_i, acc_ptr_wr_i, acc_ptr_val_i} = VEC[v][30:16];
      #1 chk($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", v), addr_o, VEC[v][15:0]);
      @(posedge clk);
    end
    @(negedge clk); idle_inputs(); #1;
    chk("R5 reg0 doubled", reg_of(0), 16'h0008);
    chk("R4 reg1", reg_of(1), 16'h1006);
    chk("R4 wrap reg2", reg_of(2), 16'hFFFF);
    chk("R5 reg3", reg_of(3), 16'hFFFB);
    chk("R6 reg5 untouched", reg_of(5), 16'h4005);
    chk("R6 R7 select", {13'd0, sel_o}, 16'd1);
    m_ar[0] = 16'h0008; m_ar[1] = 16'h1006; m_ar[2] = 16'hFFFF; m_ar[3] = 16'hFFFB;

    // R9: load beats update, direct select beats access write
    @(negedge clk); idle_inputs();
    acc_valid_i = 1; acc_indirect_i = 1; acc_op_i = 3'd1;
    acc_ptr_wr_i = 1; acc_ptr_val_i = 3'd4;
    ar_ld_i = 1; ar_ld_idx_i = 3'd1; ar_ld_val_i = 16'h2222;
    sel_ld_i = 1; sel_val_i = 3'd6;
    @(posedge clk);
    @(negedge clk); idle_inputs(); #1;
    chk("R9 load wins", reg_of(1), 16'h2222);
    chk("R9 select load wins", {13'd0, sel_o}, 16'd6);
    m_ar[1] = 16'h2222; m_sel = 3'd6;

    // R10: no valid, nothing moves
    @(negedge clk); idle_inputs();
    acc_indirect_i = 1; acc_op_i = 3'd3; acc_ptr_wr_i = 1; acc_ptr_val_i = 3'd2;
    #1 chk("R3 pointer addr", addr_o, 16'h4006);
    @(posedge clk);
    @(negedge clk); idle_inputs(); #1 check_state("R10 idle");

    // random sequence against the model: R2 R3 R4 R7 R8 R9
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk); idle_inputs();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      acc_valid_i    = lfsr[0] | lfsr[1];
      acc_indirect_i = lfsr[2] | lfsr[3];
      acc_ofs_i      = lfsr[10:4];
      acc_op_i       = lfsr[13:11];
      acc_ptr_wr_i   = lfsr[14] & lfsr[15];
      acc_ptr_val_i  = lfsr[18:16];
      page_ld_i      = (lfsr[22:19] == 4'd0);
      page_val_i     = lfsr[31:23];
      sel_ld_i       = (lfsr[25:22] == 4'd5);
      sel_val_i      = lfsr[28:26];
      ar_ld_i        = (lfsr[29:26] == 4'd3);
      ar_ld_idx_i    = lfsr[9:7];
      ar_ld_val_i    = lfsr[31:16];
      #1;
      chk("R2 R3 random addr", addr_o,
          acc_indirect_i ? m_ar[m_sel] : {m_pg, acc_ofs_i});
      if (c % 16 == 0) check_state("R4 R7 R8 random state");
      model_edge();
    end
    @(negedge clk); idle_inputs(); #1 check_state("R4 R7 R8 R9 final state");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule